// File: doc/BRIEF.md
# Prioritized Interrupt Delivery Unit

This block sits between the interrupt sources of a chip and a processor core. It records three kinds of request: a reset request pulse, a non-maskable request pulse, and updates of a six-bit maskable interrupt level. At each instruction boundary that the core signals, it makes one delivery attempt. The attempt serves the most urgent pending request: reset first, then the non-maskable request, then the maskable level. Reset and non-maskable requests both raise one shared exception strobe.

When the maskable level is served, the block writes the pending level bits into the interrupt-pending field of the cause register. It then checks them against the global enable and the per-line mask of the status register. If the request is enabled and unmasked, it raises a general interrupt strobe and drops the request. Otherwise the request stays pending and is tried again at every later boundary. A level update of zero means the source has withdrawn its request. The next attempt then clears the cause field and raises no exception.

Top module: `irq_delivery_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, all pending requests are dropped and `cause_ip_o` is cleared; both strobes are low. Requests given during reset leave no trace after release.
- R2: A pending reset request has top priority. A boundary attempt that finds it pending raises `rnmi_exc_o` and consumes the reset request only. An attempt never raises both strobes.
- R3: A pending non-maskable request is served when no reset request is pending. It raises the same `rnmi_exc_o` strobe and is then consumed.
- R4: An update (`lvl_upd_i`=1) with `lvl_i`=0 marks the level as withdrawn. The next attempt that reaches the level clears `cause_ip_o` to 0, raises no interrupt, and leaves nothing pending.
- R5: An attempt that serves a live level writes the level into `cause_ip_o`, bit i to bit i. It does this whether or not the interrupt is then delivered.
- R6: A live level is delivered only if `sr_ie_i`=1 and (level AND `sr_im_i`) is nonzero, where mask bit i enables level bit i. Delivery raises `int_exc_o` and drops the pending level.
- R7: A live level that is disabled or masked stays pending. It is attempted again at every following boundary and is delivered at the first boundary where the enable and the mask allow it.
- R8: Attempts happen only in cycles with `insn_bound_i`=1. Each strobe is a one-cycle pulse in the cycle after that boundary edge. `cause_ip_o` changes only in the cycle after a boundary.
- R9: A request that arrives in a boundary cycle takes part in that cycle's attempt. A level update in that cycle replaces the held level before it is served. A reset or non-maskable request in that cycle takes precedence over the level.
- R10: A level that is pending while reset or non-maskable requests are served keeps its value. It is served at the first boundary that finds no reset or non-maskable request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_bound_i | input | 1 | Instruction boundary strobe; a delivery attempt may occur |
| rst_req_i | input | 1 | Reset request pulse |
| nmi_req_i | input | 1 | Non-maskable request pulse |
| lvl_upd_i | input | 1 | Maskable level update strobe |
| lvl_i | input | 6 | New maskable level; zero means withdrawn |
| sr_ie_i | input | 1 | Status register global interrupt enable |
| sr_im_i | input | 6 | Status register per-line interrupt mask |
| cause_ip_o | output | 6 | Cause register interrupt-pending field |
| rnmi_exc_o | output | 1 | Shared reset / non-maskable exception strobe |
| int_exc_o | output | 1 | General interrupt exception strobe |

## Verification
Request capture and a delivery attempt can fall in the same cycle. A reset pulse, a non-maskable pulse or a level update may arrive in the very boundary cycle that serves an older request. The bench drives such arrivals together with `insn_bound_i`: a new level on top of an older masked one, and a reset pulse on top of a deliverable level. A behavioural reference model, updated on every clock, shows which request must win that attempt and what must be left pending for the next one. The outputs are compared with that model in every cycle.

// File: rtl/idu_pkg.sv
// Package: shared types for the interrupt delivery unit.
// Assumes: nothing; holds only the state encoding of the maskable level.
package idu_pkg;

    // Condition of the held maskable level
    typedef enum logic [1:0] {
        LV_NONE = 2'd0,   // nothing held
        LV_LIVE = 2'd1,   // nonzero level awaiting delivery
        LV_GONE = 2'd2    // source withdrew its request (level of zero)
    } lvl_state_e;

endpackage

// File: rtl/idu_flag.sv
// Module: idu_flag
// Holds one pulse-type request (reset or non-maskable) until it is served.
// Assumes: set_i is a single-cycle pulse; clr_i is raised only by the
// arbiter in a cycle where eff_o is high. eff_o includes a same-cycle set.
module idu_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic eff_o
);

    logic held_q;

    // Request as seen by this cycle's attempt: held or just arriving
    always_comb eff_o = held_q | set_i;

    // Keep the request until the arbiter consumes it
    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= 1'b0;
        else        held_q <= eff_o & ~clr_i;
    end

endmodule

// File: rtl/idu_level.sv
// Module: idu_level
// Holds the maskable level and its state (none / live / withdrawn).
// Assumes: service_i is high only when the arbiter served the level this
// cycle; accept_i is high only together with service_i on a live level.
module idu_level
    import idu_pkg::*;
#(
    parameter int IP_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd_i,
    input  logic [IP_W-1:0] lvl_i,
    input  logic            service_i,
    input  logic            accept_i,
    output lvl_state_e      eff_state_o,
    output logic [IP_W-1:0] eff_bits_o
);

    lvl_state_e      state_q;
    logic [IP_W-1:0] bits_q;
    logic            drop;

    // A same-cycle update replaces the held level before it is served
    always_comb begin
        if (upd_i) begin
            eff_state_o = (lvl_i == '0) ? LV_GONE : LV_LIVE;
            eff_bits_o  = lvl_i;
        end else begin
            eff_state_o = state_q;
            eff_bits_o  = bits_q;
        end
    end

    // Served level is dropped unless it was live and refused
    always_comb drop = service_i && ((eff_state_o != LV_LIVE) || accept_i);

    // Register the level that remains after this cycle's attempt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LV_NONE;
            bits_q  <= '0;
        end else if (drop) begin
            state_q <= LV_NONE;
            bits_q  <= '0;
        end else begin
            state_q <= eff_state_o;
            bits_q  <= eff_bits_o;
        end
    end

endmodule

// File: rtl/idu_arbiter.sv
// Module: idu_arbiter
// Makes one delivery decision per boundary: reset, then non-maskable,
// then the maskable level. Purely combinational.
// Assumes: inputs already include requests arriving in this cycle.
module idu_arbiter
    import idu_pkg::*;
#(
    parameter int IP_W = 6
) (
    input  logic            bound_i,
    input  logic            eff_rst_i,
    input  logic            eff_nmi_i,
    input  lvl_state_e      lvl_state_i,
    input  logic [IP_W-1:0] lvl_bits_i,
    input  logic            sr_ie_i,
    input  logic [IP_W-1:0] sr_im_i,
    output logic            clr_rst_o,
    output logic            clr_nmi_o,
    output logic            rnmi_fire_o,
    output logic            lvl_service_o,
    output logic            lvl_accept_o,
    output logic            cause_we_o,
    output logic [IP_W-1:0] cause_d_o
);

    // Fixed-priority selection of the single request served this attempt
    always_comb begin
        clr_rst_o     = 1'b0;
        clr_nmi_o     = 1'b0;
        rnmi_fire_o   = 1'b0;
        lvl_service_o = 1'b0;
        lvl_accept_o  = 1'b0;
        cause_we_o    = 1'b0;
        cause_d_o     = '0;
        if (bound_i) begin
            if (eff_rst_i) begin
                clr_rst_o   = 1'b1;
                rnmi_fire_o = 1'b1;
            end else if (eff_nmi_i) begin
                clr_nmi_o   = 1'b1;
                rnmi_fire_o = 1'b1;
            end else if (lvl_state_i == LV_LIVE) begin
                lvl_service_o = 1'b1;
                cause_we_o    = 1'b1;
                cause_d_o     = lvl_bits_i;
                if (sr_ie_i && (|(lvl_bits_i & sr_im_i)))
                    lvl_accept_o = 1'b1;
            end else if (lvl_state_i == LV_GONE) begin
                lvl_service_o = 1'b1;
                cause_we_o    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_delivery_unit.sv
// Module: irq_delivery_unit (top)
// Captures reset, non-maskable and maskable-level requests. It makes one
// prioritized delivery attempt per instruction boundary, updates the
// cause interrupt-pending field and pulses the matching exception strobe.
// Assumes: one core; status enable/mask are valid in every cycle; strobe
// outputs are registered and appear the cycle after the boundary edge.
module irq_delivery_unit
    import idu_pkg::*;
#(
    parameter int IP_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            insn_bound_i,
    input  logic            rst_req_i,
    input  logic            nmi_req_i,
    input  logic            lvl_upd_i,
    input  logic [IP_W-1:0] lvl_i,
    input  logic            sr_ie_i,
    input  logic [IP_W-1:0] sr_im_i,
    output logic [IP_W-1:0] cause_ip_o,
    output logic            rnmi_exc_o,
    output logic            int_exc_o
);

    localparam int NFLAG = 2;   // index 0: reset request, 1: non-maskable

    logic [NFLAG-1:0] flag_set, flag_clr, flag_eff;
    lvl_state_e       lvl_state;
    logic [IP_W-1:0]  lvl_bits;
    logic             rnmi_fire, lvl_service, lvl_accept, cause_we;
    logic [IP_W-1:0]  cause_d;

    always_comb flag_set = {nmi_req_i, rst_req_i};

    // One pending holder per pulse-type request
    for (genvar k = 0; k < NFLAG; k++) begin : g_flag
        idu_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (flag_set[k]),
            .clr_i (flag_clr[k]),
            .eff_o (flag_eff[k])
        );
    end

    idu_level #(.IP_W(IP_W)) u_level (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_i       (lvl_upd_i),
        .lvl_i       (lvl_i),
        .service_i   (lvl_service),
        .accept_i    (lvl_accept),
        .eff_state_o (lvl_state),
        .eff_bits_o  (lvl_bits)
    );

    idu_arbiter #(.IP_W(IP_W)) u_arb (
        .bound_i       (insn_bound_i),
        .eff_rst_i     (flag_eff[0]),
        .eff_nmi_i     (flag_eff[1]),
        .lvl_state_i   (lvl_state),
        .lvl_bits_i    (lvl_bits),
        .sr_ie_i       (sr_ie_i),
        .sr_im_i       (sr_im_i),
        .clr_rst_o     (flag_clr[0]),
        .clr_nmi_o     (flag_clr[1]),
        .rnmi_fire_o   (rnmi_fire),
        .lvl_service_o (lvl_service),
        .lvl_accept_o  (lvl_accept),
        .cause_we_o    (cause_we),
        .cause_d_o     (cause_d)
    );

    // Cause field follows the last served level; strobes last one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_ip_o <= '0;
            rnmi_exc_o <= 1'b0;
            int_exc_o  <= 1'b0;
        end else begin
            if (cause_we) cause_ip_o <= cause_d;
            rnmi_exc_o <= rnmi_fire;
            int_exc_o  <= lvl_accept;
        end
    end

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(rnmi_exc_o && int_exc_o));                                        // R2
    AST_RST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_bound_i && rst_req_i) |=> (rnmi_exc_o && !int_exc_o));        // R9
    AST_WITHDRAW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_bound_i && lvl_upd_i && (lvl_i == '0) && !flag_eff[0] && !flag_eff[1])
        |=> ((cause_ip_o == '0) && !int_exc_o));                            // R4
    AST_INT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        int_exc_o |-> $past(sr_ie_i));                                      // R6
    AST_INT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        int_exc_o |-> ((cause_ip_o & $past(sr_im_i)) != '0));               // R6
    AST_RNMI_ON_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rnmi_exc_o |-> $past(insn_bound_i));                                // R8
    AST_INT_ON_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int_exc_o |-> $past(insn_bound_i));                                 // R8
    AST_CAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(insn_bound_i) |-> $stable(cause_ip_o));                      // R8

endmodule

// File: tb/irq_delivery_unit_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model updated every clock, outputs compared
// every cycle, plus directed checks at the corner cases.
module irq_delivery_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bnd = 1'b0, rreq = 1'b0, nreq = 1'b0, upd = 1'b0;
    logic [5:0] lvl = '0;
    logic       ie = 1'b0;
    logic [5:0] im = '0;
    logic [5:0] cause;
    logic       rnmi, intx;

    int    n_chk = 0, n_fail = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // Reference model state: 0 none, 1 live, 2 withdrawn
    int m_rst = 0, m_nmi = 0, m_ls = 0, m_lb = 0, m_cause = 0;
    int m_rnmi = 0, m_int = 0;

    always #2 clk = ~clk;   // 250 MHz

    irq_delivery_unit u_dut (
        .clk (clk), .rst_n (rst_n), .insn_bound_i (bnd),
        .rst_req_i (rreq), .nmi_req_i (nmi_bit()), .lvl_upd_i (upd),
        .lvl_i (lvl), .sr_ie_i (ie), .sr_im_i (im),
        .cause_ip_o (cause), .rnmi_exc_o (rnmi), .int_exc_o (intx)
    );

    function automatic logic nmi_bit();
        return nreq;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model: serve by priority at a boundary, otherwise just record
    always @(posedge clk) begin
        int er, en, ls, lb;
        if (!rst_n) begin
            m_rst = 0; m_nmi = 0; m_ls = 0; m_lb = 0;
            m_cause = 0; m_rnmi = 0; m_int = 0;
        end else begin
            er = m_rst | int'(rreq);
            en = m_nmi | int'(nreq);
            ls = m_ls; lb = m_lb;
            if (upd) begin
                lb = int'(lvl);
                ls = (lb == 0) ? 2 : 1;
            end
            m_rnmi = 0; m_int = 0;
            if (bnd) begin
                if (er != 0)          begin m_rnmi = 1; er = 0; end
                else if (en != 0)     begin m_rnmi = 1; en = 0; end
                else if (ls == 1) begin
                    m_cause = lb;
                    if (ie && ((lb & int'(im)) != 0)) begin m_int = 1; ls = 0; end
                end else if (ls == 2) begin m_cause = 0; ls = 0; end
            end
            m_rst = er; m_nmi = en; m_ls = ls; m_lb = lb;
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({cur_tag, " cause"}, int'(cause), m_cause);
            chk({cur_tag, " rnmi"},  int'(rnmi),  m_rnmi);
            chk({cur_tag, " int"},   int'(intx),  m_int);
        end
    end

    // One cycle of stimulus, driven just after a falling edge
    task automatic cyc(input logic b, input logic r, input logic n,
                       input logic u, input logic [5:0] l);
        bnd = b; rreq = r; nreq = n; upd = u; lvl = l;
        @(negedge clk); #0.5;
    endtask

    initial begin
        @(negedge clk); #0.5;
        // R1: requests offered during reset must vanish
        cur_tag = "R1";
        cyc(0, 1, 1, 1, 6'h07);
        cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        rst_n = 1'b1;
        cyc(1, 0, 0, 0, 0);
        chk("R1 rnmi after reset", int'(rnmi), 0);
        chk("R1 cause after reset", int'(cause), 0);

        // R5/R6/R7: disabled level shows in cause, then delivered once enabled
        cur_tag = "R5"; ie = 0; im = 6'h3F;
        cyc(0, 0, 0, 1, 6'h05);
        cyc(1, 0, 0, 0, 0);
        chk("R5 cause while disabled", int'(cause), 5);
        chk("R6 no int while disabled", int'(intx), 0);
        cur_tag = "R7";
        cyc(1, 0, 0, 0, 0);
        ie = 1;
        cyc(1, 0, 0, 0, 0);
        chk("R7 delivered once enabled", int'(intx), 1);
        cyc(1, 0, 0, 0, 0);
        chk("R6 level dropped after delivery", int'(intx), 0);

        // R6/R7/R8: masked line, then unmasked; no attempt without boundary
        cur_tag = "R6"; im = 6'h1F;
        cyc(0, 0, 0, 1, 6'h20);
        cyc(1, 0, 0, 0, 0);
        chk("R6 masked line not delivered", int'(intx), 0);
        chk("R5 cause bit 5", int'(cause), 'h20);
        cur_tag = "R8"; im = 6'h3F;
        cyc(0, 0, 0, 0, 0);
        chk("R8 no attempt without boundary", int'(intx), 0);
        cyc(1, 0, 0, 0, 0);
        chk("R7 delivered once unmasked", int'(intx), 1);

        // R4: withdrawal clears cause, no interrupt afterwards
        cur_tag = "R4"; ie = 0;
        cyc(0, 0, 0, 1, 6'h03);
        cyc(1, 0, 0, 0, 0);
        chk("R5 cause holds level", int'(cause), 3);
        cyc(0, 0, 0, 1, 6'h00);
        chk("R8 cause unchanged off boundary", int'(cause), 3);
        cyc(1, 0, 0, 0, 0);
        chk("R4 cause cleared on withdraw", int'(cause), 0);
        ie = 1;
        cyc(1, 0, 0, 0, 0);
        chk("R4 no int after withdraw", int'(intx), 0);

        // R2/R3/R10: reset and NMI ahead of a deliverable level
        cur_tag = "R10"; ie = 1; im = 6'h3F;
        cyc(0, 1, 1, 1, 6'h11);
        cyc(1, 0, 0, 0, 0);
        chk("R2 reset served first", int'(rnmi), 1);
        chk("R2 no int with reset", int'(intx), 0);
        cyc(1, 0, 0, 0, 0);
        chk("R3 nmi served second", int'(rnmi), 1);
        cyc(1, 0, 0, 0, 0);
        chk("R10 level served afterwards", int'(intx), 1);
        chk("R10 level value kept", int'(cause), 'h11);
        cyc(1, 0, 0, 0, 0);
        chk("R2 nothing left pending", int'(rnmi), 0);

        // R3: NMI alone, consumed after one attempt
        cur_tag = "R3";
        cyc(1, 0, 1, 0, 0);
        chk("R3 nmi delivered", int'(rnmi), 1);
        cyc(1, 0, 0, 0, 0);
        chk("R3 nmi consumed", int'(rnmi), 0);

        // R9: same-cycle arrivals at a boundary
        cur_tag = "R9"; ie = 0;
        cyc(0, 0, 0, 1, 6'h02);
        cyc(1, 0, 0, 1, 6'h09);
        chk("R9 new level replaces old", int'(cause), 9);
        ie = 1;
        cyc(1, 1, 0, 0, 0);
        chk("R9 reset wins same-cycle", int'(rnmi), 1);
        chk("R9 level waits", int'(intx), 0);
        cyc(1, 0, 0, 0, 0);
        chk("R9 level follows", int'(intx), 1);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule